// File: doc/BRIEF.md
# Paged DMA Address Translator

This block turns a device-side DMA bus address into a physical page address using a flat, one-level table of 64-bit translation entries held in on-chip registers. The page size is a power of two chosen by a programmable page shift, which defaults to 12 (4 KiB pages). The table row is selected by the bus address shifted right by that page shift. The two least significant bits of each entry carry the access rights of the page. The remaining bits above the page offset carry the physical page base.

An external updater fills the table through a one-entry-per-cycle write port. Translation requests arrive on a valid/ready handshake and receive a registered answer one cycle later. The answer holds the page-aligned request address, the translated page address, the in-page offset mask, the decoded access code and a flag. The flag is set when the requested kind of access (read or write) is not granted.

Top module: `dma_xlate_top`

## Requirements
- R1: The row index of a lookup is the request address shifted right by the current page shift. The lookup is in range only when that index is less than `N_ENTRIES`.
- R2: `rsp_perm_o` carries bits [1:0] of the selected entry for an in-range lookup, with the codes 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R3: For an in-range lookup, `rsp_iova_o` is the request address and `rsp_phys_o` is the entry, each with the bits below the page shift forced to zero.
- R4: `rsp_mask_o` of an in-range lookup equals (1 << page shift) - 1.
- R5: An out-of-range lookup answers with access code 0, zero for both addresses and an all-ones offset mask.
- R6: Reset zeroes every table entry, so every lookup faults until its row is written. Reset also sets the page shift to 12, so `min_page_o` reads 4096.
- R7: A write with `shift_we_i` high loads `shift_i` as the page shift. The new shift applies to requests accepted at later edges. `min_page_o` always equals 1 << page shift.
- R8: A request is accepted at a rising edge where `req_valid_i` and `req_ready_o` are both high, and `rsp_valid_o` is high from the following cycle. `req_ready_o` is high whenever no response is held or `rsp_ready_i` is high.
- R9: While `rsp_valid_o` is high and `rsp_ready_i` is low, every response output stays unchanged and no new request is accepted.
- R10: A table write and a lookup of the same row at the same edge return the entry as it was before the write. A later lookup returns the new entry.
- R11: `rsp_viol_o` is high when a read is requested (`req_write_i` = 0) and code bit 0 is clear, or when a write is requested and code bit 1 is clear. An out-of-range lookup therefore always flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| shift_we_i | input | 1 | Load the page shift |
| shift_i | input | SHIFT_W | New page shift value |
| min_page_o | output | ADDR_W | Current page size, 1 << page shift |
| tbl_we_i | input | 1 | Table write enable |
| tbl_idx_i | input | IDX_W | Table row to write |
| tbl_data_i | input | ADDR_W | Entry value to write |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request can be taken |
| req_addr_i | input | ADDR_W | Bus address to translate |
| req_write_i | input | 1 | Requested access: 1 = write, 0 = read |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_iova_o | output | ADDR_W | Page-aligned request address |
| rsp_phys_o | output | ADDR_W | Translated page address |
| rsp_mask_o | output | ADDR_W | In-page offset mask |
| rsp_perm_o | output | 2 | Decoded access code |
| rsp_viol_o | output | 1 | Requested access not permitted |

## Verification
Several properties are checked on every cycle by the assertions. An accepted request always produces a response on the next cycle. A stalled response does not move. Any response has its address bits below the mask cleared. A no-access code always raises the violation flag. A table write lands in the addressed row. Only the bench scenarios can show the following behaviours: the actual translated values across page shifts, the boundary between the last row and the first out-of-range index, the old-entry result of a same-row write and lookup, and the cleared table after a reset in mid-run.

// File: rtl/dmatx_pkg.sv
package dmatx_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2,
    ACC_RDWR = 2'd3
  } acc_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dmatx_rst_sync.sv
module dmatx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dmatx_table.sv
module dmatx_table #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned IDX_W     = dmatx_pkg::idx_width(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] row_q [N_ENTRIES];
  logic [ADDR_W-1:0] row_d [N_ENTRIES];

  // next-state: only the addressed row changes
  always_comb begin
    for (int i = 0; i < int'(N_ENTRIES); i++) begin
      row_d[i] = row_q[i];
      if (wr_en && (int'(wr_idx) == i)) row_d[i] = wr_data;
    end
  end

  generate
    for (genvar g = 0; g < int'(N_ENTRIES); g++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     row_q[g] <= '0;
        else if (wr_en) row_q[g] <= row_d[g];
      end
    end
  endgenerate

  // read sees the array before this edge's write (old data on collision)
  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < int'(N_ENTRIES)) rd_data = row_q[rd_idx];
  end

  // R10: a write is visible in its row from the next cycle
  p_wr_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (row_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/dmatx_decode.sv
module dmatx_decode #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned SHIFT_W   = 6,
  parameter int unsigned IDX_W     = dmatx_pkg::idx_width(N_ENTRIES)
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               is_write,
  output logic [IDX_W-1:0]   row_idx,
  input  logic [ADDR_W-1:0]  row_entry,
  output logic [ADDR_W-1:0]  iova,
  output logic [ADDR_W-1:0]  phys,
  output logic [ADDR_W-1:0]  mask,
  output dmatx_pkg::acc_e    perm,
  output logic               viol
);
  logic [ADDR_W-1:0] off_mask;
  logic [ADDR_W-1:0] full_idx;
  logic              in_range;

  always_comb begin
    off_mask = (ADDR_W'(1) << shift) - ADDR_W'(1);
    full_idx = addr >> shift;
    in_range = (full_idx < ADDR_W'(N_ENTRIES));
    row_idx  = full_idx[IDX_W-1:0];
    if (in_range) begin
      iova = addr & ~off_mask;
      phys = row_entry & ~off_mask;
      mask = off_mask;
      perm = dmatx_pkg::acc_e'(row_entry[1:0]);
    end else begin
      iova = '0;
      phys = '0;
      mask = '1;
      perm = dmatx_pkg::ACC_NONE;
    end
    viol = is_write ? ~perm[1] : ~perm[0];
  end
endmodule

// File: rtl/dmatx_rsp_reg.sv
module dmatx_rsp_reg #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] in_iova,
  input  logic [ADDR_W-1:0] in_phys,
  input  logic [ADDR_W-1:0] in_mask,
  input  dmatx_pkg::acc_e   in_perm,
  input  logic              in_viol,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_iova,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic [ADDR_W-1:0] rsp_mask,
  output dmatx_pkg::acc_e   rsp_perm,
  output logic              rsp_viol
);
  logic              vld_q, vld_d;
  logic              load;
  logic [ADDR_W-1:0] iova_q, phys_q, mask_q;
  dmatx_pkg::acc_e   perm_q;
  logic              viol_q;

  always_comb begin
    req_ready = ~vld_q | rsp_ready;
    load      = req_valid & req_ready;
    if (load)           vld_d = 1'b1;
    else if (rsp_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iova_q <= '0;
      phys_q <= '0;
      mask_q <= '0;
      perm_q <= dmatx_pkg::ACC_NONE;
      viol_q <= 1'b0;
    end else if (load) begin
      iova_q <= in_iova;
      phys_q <= in_phys;
      mask_q <= in_mask;
      perm_q <= in_perm;
      viol_q <= in_viol;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_iova  = iova_q;
  assign rsp_phys  = phys_q;
  assign rsp_mask  = mask_q;
  assign rsp_perm  = perm_q;
  assign rsp_viol  = viol_q;

  // R8: an accepted request is answered on the next cycle
  p_accept_answers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9: a stalled response keeps every field
  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_iova) && $stable(rsp_phys)
      && $stable(rsp_mask) && $stable(rsp_perm) && $stable(rsp_viol)));

  // R3: returned addresses carry no bits inside the offset mask
  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (((rsp_iova & rsp_mask) == '0) && ((rsp_phys & rsp_mask) == '0)));

  // R11: a no-access code always flags a violation
  p_none_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_perm == dmatx_pkg::ACC_NONE)) |-> rsp_viol);
endmodule

// File: rtl/dma_xlate_top.sv
module dma_xlate_top #(
  parameter int unsigned ADDR_W        = 64,
  parameter int unsigned N_ENTRIES     = 64,
  parameter int unsigned DEFAULT_SHIFT = 12,
  parameter int unsigned SHIFT_W       = $clog2(ADDR_W),
  parameter int unsigned IDX_W         = dmatx_pkg::idx_width(N_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_we_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [ADDR_W-1:0]  min_page_o,
  input  logic               tbl_we_i,
  input  logic [IDX_W-1:0]   tbl_idx_i,
  input  logic [ADDR_W-1:0]  tbl_data_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_write_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [ADDR_W-1:0]  rsp_iova_o,
  output logic [ADDR_W-1:0]  rsp_phys_o,
  output logic [ADDR_W-1:0]  rsp_mask_o,
  output logic [1:0]         rsp_perm_o,
  output logic               rsp_viol_o
);
  logic               rst_sync_n;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [IDX_W-1:0]   row_idx;
  logic [ADDR_W-1:0]  row_entry;
  logic [ADDR_W-1:0]  dec_iova, dec_phys, dec_mask;
  dmatx_pkg::acc_e    dec_perm, out_perm;
  logic               dec_viol;

  dmatx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    shift_d = shift_we_i ? shift_i : shift_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) shift_q <= SHIFT_W'(DEFAULT_SHIFT);
    else             shift_q <= shift_d;
  end

  assign min_page_o = ADDR_W'(1) << shift_q;

  dmatx_table #(
    .ADDR_W    (ADDR_W),
    .N_ENTRIES (N_ENTRIES),
    .IDX_W     (IDX_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (tbl_we_i),
    .wr_idx  (tbl_idx_i),
    .wr_data (tbl_data_i),
    .rd_idx  (row_idx),
    .rd_data (row_entry)
  );

  dmatx_decode #(
    .ADDR_W    (ADDR_W),
    .N_ENTRIES (N_ENTRIES),
    .SHIFT_W   (SHIFT_W),
    .IDX_W     (IDX_W)
  ) u_dec (
    .addr      (req_addr_i),
    .shift     (shift_q),
    .is_write  (req_write_i),
    .row_idx   (row_idx),
    .row_entry (row_entry),
    .iova      (dec_iova),
    .phys      (dec_phys),
    .mask      (dec_mask),
    .perm      (dec_perm),
    .viol      (dec_viol)
  );

  dmatx_rsp_reg #(
    .ADDR_W (ADDR_W)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid_i),
    .req_ready (req_ready_o),
    .in_iova   (dec_iova),
    .in_phys   (dec_phys),
    .in_mask   (dec_mask),
    .in_perm   (dec_perm),
    .in_viol   (dec_viol),
    .rsp_valid (rsp_valid_o),
    .rsp_ready (rsp_ready_i),
    .rsp_iova  (rsp_iova_o),
    .rsp_phys  (rsp_phys_o),
    .rsp_mask  (rsp_mask_o),
    .rsp_perm  (out_perm),
    .rsp_viol  (rsp_viol_o)
  );

  assign rsp_perm_o = out_perm;

  // R7: the page size output always shows a single power of two
  p_page_pow2_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(min_page_o) == 1);
endmodule

// File: tb/dma_xlate_top_tb.sv
module dma_xlate_top_tb_top;
  localparam int AW = 64;
  localparam int NE = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          shift_we;
  logic [5:0]    shift_v;
  logic [AW-1:0] min_page;
  logic          tbl_we;
  logic [5:0]    tbl_idx;
  logic [AW-1:0] tbl_data;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic          rsp_valid, rsp_ready, rsp_viol;
  logic [AW-1:0] rsp_iova, rsp_phys, rsp_mask;
  logic [1:0]    rsp_perm;

  int n_run  = 0;
  int n_fail = 0;
  logic [AW-1:0] model [NE];
  int cur_shift;

  always #5 clk = ~clk;

  dma_xlate_top dut_i (
    .clk(clk), .rst_n(rst_n), .shift_we_i(shift_we), .shift_i(shift_v),
    .min_page_o(min_page), .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx),
    .tbl_data_i(tbl_data), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_iova_o(rsp_iova), .rsp_phys_o(rsp_phys),
    .rsp_mask_o(rsp_mask), .rsp_perm_o(rsp_perm), .rsp_viol_o(rsp_viol)
  );

  typedef struct packed {
    logic [5:0]    sh;
    logic [AW-1:0] addr;
    logic          wr;
    logic [1:0]    eperm;
    logic          eviol;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{6'd12, 64'h0000_0000_0000_0123, 1'b0, 2'd0, 1'b1},
    '{6'd12, 64'h0000_0000_0000_1FFF, 1'b0, 2'd1, 1'b0},
    '{6'd12, 64'h0000_0000_0000_2004, 1'b1, 2'd2, 1'b0},
    '{6'd12, 64'h0000_0000_0000_2004, 1'b0, 2'd2, 1'b1},
    '{6'd12, 64'h0000_0000_0000_3ABC, 1'b1, 2'd3, 1'b0},
    '{6'd12, 64'h0000_0000_0003_F000, 1'b0, 2'd3, 1'b0},
    '{6'd12, 64'h0000_0000_0004_0000, 1'b0, 2'd0, 1'b1},
    '{6'd16, 64'h0000_0000_0005_1234, 1'b1, 2'd1, 1'b1},
    '{6'd16, 64'h0000_0000_003F_FFFF, 1'b0, 2'd3, 1'b0},
    '{6'd16, 64'h0000_0000_0040_0000, 1'b1, 2'd0, 1'b1},
    '{6'd0,  64'h0000_0000_0000_0006, 1'b0, 2'd2, 1'b1},
    '{6'd20, 64'hFFFF_FFFF_0000_0000, 1'b0, 2'd0, 1'b1}
  };

  function automatic logic [AW-1:0] ent_val(input int i);
    logic [AW-1:0] v;
    v = {8'hA5, 24'(i * 7919), 20'(i * 4099), 12'(i * 341)};
    v[1:0] = 2'(i % 4);
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_shift(input int sh);
    @(negedge clk);
    shift_we = 1'b1;
    shift_v  = 6'(sh);
    @(negedge clk);
    shift_we = 1'b0;
    cur_shift = sh;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic w);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_model(input string req, input logic [AW-1:0] a, input logic w);
    logic [AW-1:0] m, ix, ei, ep, em;
    logic [1:0]    eperm;
    logic          ev;
    m  = (64'd1 << cur_shift) - 64'd1;
    ix = a >> cur_shift;
    if (ix < 64'(NE)) begin
      ei = a & ~m; ep = model[ix[5:0]] & ~m; em = m; eperm = model[ix[5:0]][1:0];
    end else begin
      ei = '0; ep = '0; em = '1; eperm = 2'd0;
    end
    ev = w ? ~eperm[1] : ~eperm[0];
    chk("R8", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R3", "iova", rsp_iova, ei);
    chk(req,  "phys", rsp_phys, ep);
    chk("R4", "mask", rsp_mask, em);
    chk("R2", "perm", 64'(rsp_perm), 64'(eperm));
    chk("R11", "viol", 64'(rsp_viol), 64'(ev));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cur_shift = 12;
    for (int i = 0; i < NE; i++) model[i] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] s_iova, s_phys, s_mask;
    logic [1:0]    s_perm;
    logic [AW-1:0] oldv, newv;
    shift_we = 0; shift_v = '0; tbl_we = 0; tbl_idx = '0; tbl_data = '0;
    req_valid = 0; req_addr = '0; req_write = 0; rsp_ready = 1;
    do_reset();

    // R6: reset state
    chk("R6", "min_page", min_page, 64'd4096);
    chk("R8", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    chk("R8", "req_ready idle", 64'(req_ready), 64'd1);
    lookup(64'h5000, 1'b0);
    check_model("R6", 64'h5000, 1'b0);
    chk("R6", "unprogrammed perm", 64'(rsp_perm), 64'd0);

    // program the table
    for (int i = 0; i < NE; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = 6'(i); tbl_data = ent_val(i);
      model[i] = ent_val(i);
    end
    @(negedge clk);
    tbl_we = 1'b0;

    // vector walk: R1 R2 R3 R4 R5 R11
    for (int v = 0; v < NV; v++) begin
      if (int'(VECS[v].sh) != cur_shift) begin
        set_shift(int'(VECS[v].sh));
        chk("R7", "min_page", min_page, 64'd1 << cur_shift);
      end
      lookup(VECS[v].addr, VECS[v].wr);
      check_model("R1", VECS[v].addr, VECS[v].wr);
      chk("R2", "vector perm", 64'(rsp_perm), 64'(VECS[v].eperm));
      chk("R11", "vector viol", 64'(rsp_viol), 64'(VECS[v].eviol));
      if ((VECS[v].addr >> VECS[v].sh) >= 64'(NE))
        chk("R5", "oob mask", rsp_mask, '1);
    end

    // R10: same-edge write and lookup of row 7
    set_shift(12);
    oldv = model[7];
    newv = 64'h1234_5678_9ABC_D003;
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 6'd7; tbl_data = newv;
    req_valid = 1'b1; req_addr = 64'h7010; req_write = 1'b0;
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    chk("R10", "old entry", rsp_phys, oldv & ~64'hFFF);
    model[7] = newv;
    lookup(64'h7010, 1'b1);
    check_model("R10", 64'h7010, 1'b1);

    // R9: backpressure
    rsp_ready = 1'b0;
    lookup(64'h3123, 1'b1);
    s_iova = rsp_iova; s_phys = rsp_phys; s_mask = rsp_mask; s_perm = rsp_perm;
    req_valid = 1'b1; req_addr = 64'h9000; req_write = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "ready low", 64'(req_ready), 64'd0);
    chk("R9", "valid held", 64'(rsp_valid), 64'd1);
    chk("R9", "iova held", rsp_iova, s_iova);
    chk("R9", "phys held", rsp_phys, s_phys);
    chk("R9", "mask held", rsp_mask, s_mask);
    chk("R9", "perm held", 64'(s_perm), 64'(rsp_perm));
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_model("R8", 64'h9000, 1'b0);
    @(negedge clk);
    chk("R8", "drained", 64'(rsp_valid), 64'd0);

    // R7: shift change then reset restores everything (R6)
    set_shift(16);
    chk("R7", "min_page 64K", min_page, 64'd65536);
    do_reset();
    chk("R6", "min_page after reset", min_page, 64'd4096);
    lookup(64'h2004, 1'b0);
    check_model("R6", 64'h2004, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule